// File: doc/BRIEF.md
# Mailbox Command and Reply Port

This block is the controller-side register window through which a host hands command bus addresses to the device and collects completion words back. The host sees a small register bus with an address, a write strobe with data and a read strobe with same-cycle read data. Writing the request register places a 32-bit command address in an inbound queue. Device logic drains that queue through a valid/pop pair. In the other direction, device logic pushes completion words into an outbound queue, and each host read of the reply register takes one word from it.

An interrupt line tells the host that completions are waiting. The mask register works inverted: a cleared disable bit lets the interrupt through. A strap input picks which of two bit positions serves as both the disable bit and the pending bit. The block also keeps a running count of commands posted but not yet answered, and raises a flag when that count reaches a configured ceiling. A readiness word tells the host when the firmware is up.

Top module: `mbx_port`

## Requirements
- R1: A host write to offset 0x40 while the inbound queue has room enqueues the write data; `req_valid` is high while the queue holds words, and `req_data` presents them oldest first, one per `req_pop`.
- R2: A host read of offset 0x44 returns the oldest outbound word and removes it. When the outbound queue is empty, the read returns 0xFFFFFFFF and removes nothing.
- R3: The mask register at offset 0x34 reads back the last value written to it. Its reset value is 0x0000000C.
- R4: The disable bit is bit 3 when `strap_alt` is 0 and bit 2 when `strap_alt` is 1. `irq` is high exactly when the outbound queue is non-empty and the selected disable bit is clear.
- R5: Status at offset 0x30 shows the pending flag in the same bit position as R4. The flag is 1 whenever the outbound queue is non-empty, whatever the mask holds. Bit 0 holds the overflow flag, and all other bits read 0.
- R6: Offset 0xB0 reads 0xFFFF0000 while `fw_ready` is high and 0 otherwise.
- R7: `pend_count` rises by one on each accepted request write and falls by one on each non-empty reply read. An empty reply read leaves it unchanged. `cmd_full` is high while `pend_count` is at or above MAX_OUT.
- R8: A request write while the inbound queue is full is dropped. The queue contents and `pend_count` stay unchanged, and status bit 0 is set and stays set until reset.
- R9: Reads of unmapped offsets return 0. Writes to unmapped offsets change neither the mask nor the inbound queue.
- R10: After reset, `req_valid`, `irq`, `cmd_full` and `pend_count` are 0, status reads 0 and the mask reads 0x0000000C.
- R11: A device push while the outbound queue is full (`rpl_full` high) is dropped. The words already queued are returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Selects the bit position for disable and pending: 0 selects bit 3, 1 selects bit 2 |
| fw_ready | input | 1 | Firmware-ready indication for the readiness word |
| bus_addr | input | ADDR_W | Host byte offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rd | input | 1 | Host read strobe; a reply read takes effect at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| req_valid | output | 1 | Inbound queue holds a command address |
| req_data | output | 32 | Oldest command address |
| req_pop | input | 1 | Device takes the oldest command address |
| rpl_push | input | 1 | Device pushes a completion word |
| rpl_data | input | 32 | Completion word to push |
| rpl_full | output | 1 | Outbound queue is full |
| irq | output | 1 | Interrupt request to the host |
| cmd_full | output | 1 | Outstanding count is at or above MAX_OUT |
| pend_count | output | CNT_W | Commands posted but not yet answered |

## Verification
On every cycle, the assertions check that the outstanding count moves by exactly one step per accepted write or answered read and otherwise holds. They also check that a queue never exceeds its depth, that a pop on an empty queue and a push on a full queue leave its level alone, that an empty reply read returns the all-ones sentinel, and that the overflow flag never clears on its own. Only the bench scenarios can show the data side: words come out in order, each strap setting picks the right bit positions, a dropped write does not appear later among the queued addresses, and the readiness word and unmapped offsets read as required.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef logic [31:0] word_t;

   localparam logic [7:0] OFS_STATUS  = 8'h30;
   localparam logic [7:0] OFS_MASK    = 8'h34;
   localparam logic [7:0] OFS_REQ     = 8'h40;
   localparam logic [7:0] OFS_RPL     = 8'h44;
   localparam logic [7:0] OFS_READY   = 8'hB0;

   localparam word_t EMPTY_WORD = 32'hFFFF_FFFF;
   localparam word_t READY_WORD = 32'hFFFF_0000;
   localparam word_t MASK_RESET = 32'h0000_000C;

   localparam logic [4:0] DIS_BIT_MAIN = 5'd3;
   localparam logic [4:0] DIS_BIT_ALT  = 5'd2;
   localparam int         OVF_BIT      = 0;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  LVL_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   initial begin
      if (DEPTH < 1) $error("mbx_fifo: DEPTH must be at least 1");
      if (W < 1)     $error("mbx_fifo: W must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] level;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R1: occupancy never passes the configured depth
   a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R2: a pop on an empty queue removes nothing
   a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && level == '0) |=> (level == '0));

   // R11: a push on a full queue adds nothing
   a_r11_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level == LVL_W'(DEPTH)) |=> $stable(level) && $stable(wr_ptr));
endmodule

// File: rtl/mbx_tally.sv
module mbx_tally #(
   parameter int CNT_W = 5,
   parameter int LIMIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);
   initial begin
      if (LIMIT < 1)                 $error("mbx_tally: LIMIT must be at least 1");
      if (LIMIT >= (1 << CNT_W))     $error("mbx_tally: CNT_W too narrow for LIMIT");
   end

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (count != TOP) count <= count + 1'b1;
            2'b01:   if (count != '0)  count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign at_limit = (count >= CNT_W'(LIMIT));

   // R7: one step up per accepted command
   a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && count != TOP) |=> (count == $past(count) + 1'b1));

   // R7: one step down per answered command
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && count != '0) |=> (count == $past(count) - 1'b1));

   // R7: no movement without an event
   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec) |=> $stable(count));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int REQ_DEPTH = 8,
   parameter int RPL_DEPTH = 8,
   parameter int MAX_OUT   = 6,
   localparam int CNT_W    = $clog2(MAX_OUT + REQ_DEPTH + RPL_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_alt,
   input  logic              fw_ready,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              req_valid,
   output logic [31:0]       req_data,
   input  logic              req_pop,
   input  logic              rpl_push,
   input  logic [31:0]       rpl_data,
   output logic              rpl_full,
   output logic              irq,
   output logic              cmd_full,
   output logic [CNT_W-1:0]  pend_count
);
   initial begin
      if (ADDR_W < 8) $error("mbx_port: ADDR_W must cover offset 0xB0");
   end

   // address decode
   logic at_status, at_mask, at_req, at_rpl, at_ready;
   assign at_status = (bus_addr == ADDR_W'(OFS_STATUS));
   assign at_mask   = (bus_addr == ADDR_W'(OFS_MASK));
   assign at_req    = (bus_addr == ADDR_W'(OFS_REQ));
   assign at_rpl    = (bus_addr == ADDR_W'(OFS_RPL));
   assign at_ready  = (bus_addr == ADDR_W'(OFS_READY));

   logic wr_req, wr_mask, rd_rpl;
   assign wr_req  = bus_wr && at_req;
   assign wr_mask = bus_wr && at_mask;
   assign rd_rpl  = bus_rd && at_rpl;

   // inbound command queue
   logic req_empty, req_full;
   mbx_fifo #(.W(32), .DEPTH(REQ_DEPTH)) u_req_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_req),
      .wdata (bus_wdata),
      .pop   (req_pop),
      .rdata (req_data),
      .empty (req_empty),
      .full  (req_full)
   );
   assign req_valid = !req_empty;

   // outbound completion queue
   logic  rpl_empty;
   word_t rpl_head;
   mbx_fifo #(.W(32), .DEPTH(RPL_DEPTH)) u_rpl_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rpl_push),
      .wdata (rpl_data),
      .pop   (rd_rpl),
      .rdata (rpl_head),
      .empty (rpl_empty),
      .full  (rpl_full)
   );

   // outstanding-command tally
   logic req_taken, rpl_taken, req_dropped;
   assign req_taken   = wr_req && !req_full;
   assign req_dropped = wr_req && req_full;
   assign rpl_taken   = rd_rpl && !rpl_empty;

   mbx_tally #(.CNT_W(CNT_W), .LIMIT(MAX_OUT)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (req_taken),
      .dec      (rpl_taken),
      .count    (pend_count),
      .at_limit (cmd_full)
   );

   // mask and sticky overflow
   word_t mask_q;
   logic  ovf_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= MASK_RESET;
         ovf_q  <= 1'b0;
      end else begin
         if (wr_mask)     mask_q <= bus_wdata;
         if (req_dropped) ovf_q  <= 1'b1;
      end
   end

   // strap-selected bit position for disable and pending
   logic [4:0] sel_bit;
   assign sel_bit = strap_alt ? DIS_BIT_ALT : DIS_BIT_MAIN;

   assign irq = !rpl_empty && !mask_q[sel_bit];

   word_t status_word;
   always_comb begin
      status_word          = '0;
      status_word[sel_bit] = !rpl_empty;
      status_word[OVF_BIT] = ovf_q;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (at_status)     bus_rdata = status_word;
         else if (at_mask)  bus_rdata = mask_q;
         else if (at_rpl)   bus_rdata = rpl_empty ? EMPTY_WORD : rpl_head;
         else if (at_ready) bus_rdata = fw_ready ? READY_WORD : '0;
      end
   end

   // R8: overflow flag holds until reset
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R8: a dropped request does not move the tally
   a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      req_dropped |=> $stable(pend_count));

   // R2: empty reply read returns the sentinel
   a_r2_empty_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rpl && rpl_empty) |-> (bus_rdata == EMPTY_WORD));

   // R4: a raised interrupt means a completion is waiting
   a_r4_irq_has_reply: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status_word[sel_bit]);
endmodule

// File: tb/sim_mbx_port.sv
module sim_mbx_port;
   localparam int CNT_W = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_alt = 1'b0;
   logic        fw_ready = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        req_valid;
   logic [31:0] req_data;
   logic        req_pop = 1'b0;
   logic        rpl_push = 1'b0;
   logic [31:0] rpl_data = '0;
   logic        rpl_full;
   logic        irq;
   logic        cmd_full;
   logic [CNT_W-1:0] pend_count;

   always #4 clk = ~clk;   // 125 MHz

   mbx_port #(.ADDR_W(8), .REQ_DEPTH(8), .RPL_DEPTH(8), .MAX_OUT(6)) u0 (
      .clk, .rst_n, .strap_alt, .fw_ready, .bus_addr, .bus_wr, .bus_wdata,
      .bus_rd, .bus_rdata, .req_valid, .req_data, .req_pop, .rpl_push,
      .rpl_data, .rpl_full, .irq, .cmd_full, .pend_count
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic dev_push(input logic [31:0] d);
      @(negedge clk);
      rpl_data = d; rpl_push = 1'b1;
      @(posedge clk); #1;
      rpl_push = 1'b0;
   endtask

   task automatic dev_pop(output logic [31:0] d, output logic v);
      @(negedge clk);
      v = req_valid; d = req_data; req_pop = 1'b1;
      @(posedge clk); #1;
      req_pop = 1'b0;
   endtask

   // op: 0 host write, 1 host read and compare, 2 device push, 3 device pop and compare
   localparam int NV = 14;
   localparam logic [73:0] VEC [NV] = '{
      {2'd1, 8'h34, 32'h0000_0000, 32'h0000_000C},  // R3 reset mask
      {2'd0, 8'h40, 32'h1000_0040, 32'h0000_0000},  // R1
      {2'd0, 8'h40, 32'h2000_0080, 32'h0000_0000},  // R1
      {2'd3, 8'h00, 32'h0000_0000, 32'h1000_0040},  // R1 oldest first
      {2'd3, 8'h00, 32'h0000_0000, 32'h2000_0080},  // R1
      {2'd1, 8'h44, 32'h0000_0000, 32'hFFFF_FFFF},  // R2 empty sentinel
      {2'd2, 8'h00, 32'hA5A5_0001, 32'h0000_0000},  // device push
      {2'd1, 8'h30, 32'h0000_0000, 32'h0000_0008},  // R5 pending bit 3
      {2'd0, 8'h34, 32'h0000_0000, 32'h0000_0000},  // R3 write mask
      {2'd1, 8'h34, 32'h0000_0000, 32'h0000_0000},  // R3 readback
      {2'd1, 8'h44, 32'h0000_0000, 32'hA5A5_0001},  // R2 pop word
      {2'd1, 8'h30, 32'h0000_0000, 32'h0000_0000},  // R5 pending cleared
      {2'd1, 8'h50, 32'h0000_0000, 32'h0000_0000},  // R9 unmapped read
      {2'd1, 8'hB0, 32'h0000_0000, 32'h0000_0000}   // R6 not ready
   };

   initial begin
      logic [31:0] rd;
      logic        v;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 req_valid", {31'd0, req_valid}, 32'd0);
      check("R10 irq", {31'd0, irq}, 32'd0);
      check("R10 cmd_full", {31'd0, cmd_full}, 32'd0);
      check("R10 pend_count", {27'd0, pend_count}, 32'd0);
      bus_read(8'h30, rd); check("R10 status", rd, 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [1:0]  op;
         logic [7:0]  a;
         logic [31:0] d, e;
         {op, a, d, e} = VEC[i];
         case (op)
            2'd0: bus_write(a, d);
            2'd1: begin bus_read(a, rd); check($sformatf("R1-table vec %0d", i), rd, e); end
            2'd2: dev_push(d);
            default: begin dev_pop(rd, v); check($sformatf("R1 pop vec %0d", i), rd, e); end
         endcase
      end
      @(negedge clk);
      check("R7 count after table", {27'd0, pend_count}, 32'd1);

      // R4 interrupt gating and strap selection
      dev_push(32'h0000_BEEF);
      @(negedge clk); check("R4 irq enabled", {31'd0, irq}, 32'd1);
      bus_write(8'h34, 32'h8);
      @(negedge clk); check("R4 irq masked bit3", {31'd0, irq}, 32'd0);
      bus_read(8'h30, rd); check("R5 pending while masked", rd, 32'h8);
      bus_write(8'h34, 32'h4);
      @(negedge clk); check("R4 bit2 ignored main", {31'd0, irq}, 32'd1);
      strap_alt = 1'b1;
      @(negedge clk); check("R4 alt bit2 masks", {31'd0, irq}, 32'd0);
      bus_read(8'h30, rd); check("R5 alt pending bit2", rd, 32'h4);
      strap_alt = 1'b0;
      bus_write(8'h34, 32'h0);
      bus_read(8'h44, rd); check("R2 drain", rd, 32'h0000_BEEF);
      @(negedge clk);
      check("R4 irq after drain", {31'd0, irq}, 32'd0);
      check("R7 count zero", {27'd0, pend_count}, 32'd0);

      // R6 readiness word
      fw_ready = 1'b1;
      bus_read(8'hB0, rd); check("R6 ready word", rd, 32'hFFFF_0000);

      // R9 unmapped write
      bus_write(8'h50, 32'h0000_0008);
      bus_read(8'h34, rd); check("R9 mask untouched", rd, 32'h0);
      @(negedge clk); check("R9 no enqueue", {31'd0, req_valid}, 32'd0);

      // R7 limit and R8 overflow
      for (int i = 0; i < 5; i++) bus_write(8'h40, 32'h100 + i);
      @(negedge clk);
      check("R7 count 5", {27'd0, pend_count}, 32'd5);
      check("R7 not full at 5", {31'd0, cmd_full}, 32'd0);
      bus_write(8'h40, 32'h105);
      @(negedge clk);
      check("R7 full at 6", {31'd0, cmd_full}, 32'd1);
      bus_write(8'h40, 32'h106);
      bus_write(8'h40, 32'h107);
      bus_write(8'h40, 32'hDEAD);
      @(negedge clk);
      check("R8 count unchanged", {27'd0, pend_count}, 32'd8);
      bus_read(8'h30, rd); check("R8 overflow bit", rd, 32'h1);
      for (int i = 0; i < 8; i++) begin
         dev_pop(rd, v);
         if (i == 0 || i == 7) check("R8 queue contents", rd, 32'h100 + i);
      end
      @(negedge clk);
      check("R8 dropped word absent", {31'd0, req_valid}, 32'd0);
      bus_read(8'h30, rd); check("R8 overflow sticky", rd, 32'h1);

      // R11 reply overflow
      for (int i = 0; i < 9; i++) dev_push(32'hC0 + i);
      @(negedge clk); check("R11 rpl_full", {31'd0, rpl_full}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         bus_read(8'h44, rd);
         check("R11 reply order", rd, 32'hC0 + i);
      end
      bus_read(8'h44, rd); check("R11 extra word dropped", rd, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R7 count after drain", {27'd0, pend_count}, 32'd0);
      check("R7 full cleared", {31'd0, cmd_full}, 32'd0);

      // R10 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      bus_read(8'h34, rd); check("R10 mask after reset", rd, 32'h0000_000C);
      bus_read(8'h30, rd); check("R10 status after reset", rd, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule